// File: doc/BRIEF.md
# Protected Serial Configuration Register

This block is the main control register of a serial communication engine, reached over an APB-style bus. It holds the engine's setup: which bit goes first, clock polarity, whether the link is clocked or free-running, the frame type, where the receive sample point sits, the oversampling rate, which pads carry transmit and receive data, when an overflow is flagged, whether the engine runs while the chip idles, and the operating mode. Next to this setup it holds an enable bit and a soft reset bit.

The setup fields are frozen whenever the enable bit reads 1. Changes to the enable bit and soft resets are handed to the slower engine clock domain. That handover is modelled as a fixed handshake of `SYNC_CYCLES` bus clock cycles. While a handover is pending, a busy flag is shown in a second register. A soft reset wipes the setup, drops the enable and overrides everything else written in the same access. Until the reset has finished, the block answers writes with an error response and reads with the reset value.

Top module: `ctrl_reg`

## Requirements
- R1: After reset, the control word at address 0x0 reads 0x00000000, the busy word at 0x4 reads 0, and `core_en` and `core_rst` are low.
- R2: Setup field layout of the control word: bit 22 LSB-first, bit 21 clock invert, bit 20 synchronous mode, bits 19:16 frame type, bits 15:14 sample adjust, bits 13:12 receive pad, bits 11:10 transmit pad, bits 9:7 sample rate, bit 6 immediate overflow notify, bit 5 run while idle, bits 4:2 mode. The enable bit is bit 1 and the soft reset bit is bit 0. While the enable bit reads 0, a write stores bits 22:2 as written, and the same value is seen on `cfg_word`.
- R3: Bits 31:23 of the control word read 0 and ignore writes.
- R4: While the enable bit reads 1 before a write, that write leaves bits 22:2 unchanged. The enable bit itself is still written.
- R5: A write that changes the enable bit shows the new value on read at once. It raises busy bit 1 at 0x4 for exactly `SYNC_CYCLES` cycles, and `core_en` takes the new value when that window ends.
- R6: A write with bit 0 set clears every field and the enable bit and discards all other written bits. It also drops `core_en` and raises `core_rst` and busy bit 0 for exactly `SYNC_CYCLES` cycles.
- R7: Writing bit 0 as 0 starts no reset. `core_rst` and busy bit 0 stay low.
- R8: While a reset is in progress, a write gets `pslverr` high in its access phase and has no effect, and a read of 0x0 returns 0x00000001.
- R9: Writes to 0x4 and to unused addresses have no effect and give no error. Unused addresses read 0.
- R10: `pready` is always high. `pslverr` is high only in the access phase of a write during a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | AW | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Transfer ready (tied high) |
| pslverr | output | 1 | Error response |
| cfg_word | output | 32 | Setup fields and enable bit as stored |
| core_en | output | 1 | Enable as seen by the engine domain |
| core_rst | output | 1 | Soft reset in progress |

## Verification
On every cycle, the checker enforces the freeze of the setup fields while enabled, the clearing done by a soft reset, the error response and the 0x1 read value during a reset, and the limit on how long enable-busy can stay high. It also checks that `core_en` changes only as a handover ends. Only the bench scenarios show that every individual bit of the word is writable or reserved, that busy windows last exactly `SYNC_CYCLES` cycles, that a write rejected during a reset leaves nothing behind, and that the busy word reads back correctly.

// File: rtl/ctrl_pkg.sv
package ctrl_pkg;
    localparam int DW        = 32;
    localparam int BIT_RST   = 0;
    localparam int BIT_EN    = 1;
    localparam int CFG_LO    = 2;
    localparam int CFG_W     = 21;
    localparam int CFG_HI    = CFG_LO + CFG_W - 1;
    localparam int RSVD_W    = DW - CFG_HI - 1;

    // packed MSB first: lsb_first sits at bit 22, mode at bits 4:2
    typedef struct packed {
        logic       lsb_first;
        logic       clk_inv;
        logic       sync_mode;
        logic [3:0] frame;
        logic [1:0] samp_adj;
        logic [1:0] rx_pad;
        logic [1:0] tx_pad;
        logic [2:0] samp_rate;
        logic       ovf_now;
        logic       run_idle;
        logic [2:0] mode;
    } cfg_t;

    localparam logic [7:0] ADDR_CTRL = 8'h00;
    localparam logic [7:0] ADDR_BUSY = 8'h04;
endpackage

// File: rtl/ctrl_sync.sv
module ctrl_sync #(
    parameter int CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic abort,
    output logic busy,
    output logic done
);
    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } st_t;

    st_t s_d, s_q;
    logic fin;

    always_comb begin
        s_d  = s_q;
        fin  = s_q.busy && (s_q.cnt == LAST);
        done = fin && !start && !abort;
        if (abort) begin
            s_d.busy = 1'b0;
            s_d.cnt  = '0;
        end else if (start) begin
            s_d.busy = 1'b1;
            s_d.cnt  = '0;
        end else if (fin) begin
            s_d.busy = 1'b0;
            s_d.cnt  = '0;
        end else if (s_q.busy) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy = s_q.busy;
endmodule

// File: rtl/ctrl_fields.sv
module ctrl_fields
    import ctrl_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    output cfg_t          cfg,
    output logic          enable,
    output logic          rst_start,
    output logic          en_start
);
    typedef struct packed {
        cfg_t cfg;
        logic en;
    } fld_t;

    fld_t f_d, f_q;

    always_comb begin
        f_d       = f_q;
        rst_start = 1'b0;
        en_start  = 1'b0;
        if (wr) begin
            if (wdata[BIT_RST]) begin
                rst_start = 1'b1;
                f_d       = '0;
            end else begin
                if (!f_q.en) f_d.cfg = cfg_t'(wdata[CFG_HI:CFG_LO]);
                f_d.en   = wdata[BIT_EN];
                en_start = wdata[BIT_EN] != f_q.en;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign cfg    = f_q.cfg;
    assign enable = f_q.en;
endmodule

// File: rtl/ctrl_reg.sv
module ctrl_reg
    import ctrl_pkg::*;
#(
    parameter int AW          = 4,
    parameter int SYNC_CYCLES = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          psel,
    input  logic          penable,
    input  logic          pwrite,
    input  logic [AW-1:0] paddr,
    input  logic [31:0]   pwdata,
    output logic [31:0]   prdata,
    output logic          pready,
    output logic          pslverr,
    output logic [31:0]   cfg_word,
    output logic          core_en,
    output logic          core_rst
);
    localparam logic [AW-1:0] A_CTRL = AW'(ADDR_CTRL);
    localparam logic [AW-1:0] A_BUSY = AW'(ADDR_BUSY);

    logic  access, wr_ctrl;
    logic  rst_start, en_start;
    logic  rst_busy, rst_done;
    logic  en_busy, en_done;
    logic  enable;
    cfg_t  cfg;
    logic  cen_d, cen_q;

    assign access  = psel && penable;
    assign wr_ctrl = access && pwrite && (paddr == A_CTRL) && !rst_busy;

    ctrl_fields u_fields (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (wr_ctrl),
        .wdata     (pwdata),
        .cfg       (cfg),
        .enable    (enable),
        .rst_start (rst_start),
        .en_start  (en_start)
    );

    ctrl_sync #(.CYCLES(SYNC_CYCLES)) u_sync_rst (
        .clk   (clk),
        .rst_n (rst_n),
        .start (rst_start),
        .abort (1'b0),
        .busy  (rst_busy),
        .done  (rst_done)
    );

    ctrl_sync #(.CYCLES(SYNC_CYCLES)) u_sync_en (
        .clk   (clk),
        .rst_n (rst_n),
        .start (en_start),
        .abort (rst_start),
        .busy  (en_busy),
        .done  (en_done)
    );

    always_comb begin
        cen_d = cen_q;
        if (rst_start)    cen_d = 1'b0;
        else if (en_done) cen_d = enable;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cen_q <= 1'b0;
        else        cen_q <= cen_d;
    end

    always_comb begin
        prdata = '0;
        if (paddr == A_CTRL) begin
            if (rst_busy) prdata = 32'h1;
            else          prdata = {{RSVD_W{1'b0}}, cfg, enable, 1'b0};
        end else if (paddr == A_BUSY) begin
            prdata = {30'b0, en_busy, rst_busy};
        end
    end

    assign pready   = 1'b1;
    assign pslverr  = access && pwrite && rst_busy;
    assign cfg_word = {{RSVD_W{1'b0}}, cfg, enable, 1'b0};
    assign core_en  = cen_q;
    assign core_rst = rst_busy;
endmodule

// File: rtl/ctrl_reg_chk.sv
module ctrl_reg_chk
    import ctrl_pkg::*;
#(
    parameter int AW          = 4,
    parameter int SYNC_CYCLES = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          psel,
    input logic          penable,
    input logic          pwrite,
    input logic [AW-1:0] paddr,
    input logic [31:0]   pwdata,
    input logic [31:0]   prdata,
    input logic          pslverr,
    input logic [31:0]   cfg_word,
    input logic          core_en,
    input logic          core_rst,
    input logic          en_busy
);
    logic ctrl_wr;
    int   en_run;

    assign ctrl_wr = psel && penable && pwrite && (paddr == AW'(ADDR_CTRL));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       en_run <= 0;
        else if (en_busy) en_run <= en_run + 1;
        else              en_run <= 0;
    end

    assert_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && cfg_word[BIT_EN] && !core_rst && !pwdata[BIT_RST])
        |=> $stable(cfg_word[CFG_HI:CFG_LO]));

    assert_wipe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !core_rst && pwdata[BIT_RST]) |=> (core_rst && cfg_word == 32'h0 && !core_en));

    assert_no_rst_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !core_rst && !pwdata[BIT_RST]) |=> !core_rst);

    assert_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && pwrite && core_rst) |-> pslverr);

    assert_rd_rst_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (core_rst && paddr == AW'(ADDR_CTRL)) |-> (prdata == 32'h1));

    assert_err_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(psel && penable && pwrite) |-> !pslverr);

    assert_busy_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        en_run <= SYNC_CYCLES);

    assert_cen_hand_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_en) |-> $past(en_busy));
endmodule

bind ctrl_reg ctrl_reg_chk #(.AW(AW), .SYNC_CYCLES(SYNC_CYCLES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .paddr    (paddr),
    .pwdata   (pwdata),
    .prdata   (prdata),
    .pslverr  (pslverr),
    .cfg_word (cfg_word),
    .core_en  (core_en),
    .core_rst (core_rst),
    .en_busy  (en_busy)
);

// File: tb/sim_ctrl_reg.sv
`timescale 1ns/1ps
module sim_ctrl_reg;
    localparam int AW   = 4;
    localparam int SYNC = 3;
    localparam logic [31:0] CFG_MASK = ((32'h1 << 21) - 32'h1) << 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [AW-1:0] paddr = '0;
    logic [31:0]   pwdata = '0;
    logic [31:0]   prdata, cfg_word;
    logic          pready, pslverr, core_en, core_rst;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    ctrl_reg #(.AW(AW), .SYNC_CYCLES(SYNC)) u0 (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .cfg_word(cfg_word), .core_en(core_en), .core_rst(core_rst)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // starts and ends at a negedge with the bus idle
    task automatic apb_write(input logic [AW-1:0] a, input logic [31:0] d, output logic err);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        #1;
        err = pslverr;
        check("R10 pready", {31'b0, pready}, 32'h1);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_read(input logic [AW-1:0] a, output logic [31:0] d);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        #1;
        d = prdata;
        check("R10 rd no err", {31'b0, pslverr}, 32'h0);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic wr_ok(input logic [AW-1:0] a, input logic [31:0] d, input string req);
        logic e;
        apb_write(a, d, e);
        check(req, {31'b0, e}, 32'h0);
    endtask

    task automatic wait_flag(input bit want_en, output int n);
        n = 0;
        while (((want_en && core_en == 1'b0) || (!want_en && core_rst == 1'b1)) && n < 50) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic wait_cen_low(output int n);
        n = 0;
        while (core_en == 1'b1 && n < 50) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(20000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic        e;
        int          n;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        apb_read(4'h0, rd); check("R1 ctrl", rd, 32'h0);
        apb_read(4'h4, rd); check("R1 busy", rd, 32'h0);
        check("R1 core_en", {31'b0, core_en}, 32'h0);
        check("R1 core_rst", {31'b0, core_rst}, 32'h0);

        // R2/R3 single-bit sweep while disabled
        for (int b = 2; b < 32; b++) begin
            logic [31:0] w;
            w = 32'h1 << b;
            wr_ok(4'h0, w, "R2 wr");
            apb_read(4'h0, rd);
            if (b > 22) check("R3 reserved", rd, 32'h0);
            else        check("R2 field bit", rd, w & CFG_MASK);
            check("R2 cfg_word", cfg_word, w & CFG_MASK);
            check("R7 no rst", {31'b0, core_rst}, 32'h0);
        end

        // R3 all reserved ones
        wr_ok(4'h0, 32'hFF80_0000 | 32'h0015_5554, "R3 wr");
        apb_read(4'h0, rd); check("R3 mixed", rd, 32'h0015_5554);

        // R5 enable handshake with new setup
        wr_ok(4'h0, 32'h002A_AAA8 | 32'h2, "R5 wr");
        wait_flag(1'b1, n); check("R5 latency", n, SYNC);
        apb_read(4'h0, rd); check("R5 readback", rd, 32'h002A_AAAA);

        // R4 protection: full sweep of setup bits while enabled
        for (int b = 2; b < 23; b++) begin
            wr_ok(4'h0, (32'h1 << b) | 32'h2, "R4 wr");
            apb_read(4'h0, rd); check("R4 frozen", rd, 32'h002A_AAAA);
        end
        wr_ok(4'h0, 32'h007F_FFFE, "R4 wr all");
        apb_read(4'h0, rd); check("R4 frozen all", rd, 32'h002A_AAAA);
        check("R4 core_en held", {31'b0, core_en}, 32'h1);

        // R5 disable: busy visible in status right after the write
        wr_ok(4'h0, 32'h0, "R5 dis");
        apb_read(4'h4, rd); check("R5 busy bit", rd, 32'h2);
        apb_read(4'h0, rd); check("R5 dis read", rd, 32'h002A_AAA8);
        wait_cen_low(n);
        check("R5 core_en low", {31'b0, core_en}, 32'h0);
        apb_read(4'h4, rd); check("R5 busy clear", rd, 32'h0);

        // R9 busy word and unused addresses
        wr_ok(4'h4, 32'hFFFF_FFFF, "R9 wr busy");
        apb_read(4'h4, rd); check("R9 busy ro", rd, 32'h0);
        wr_ok(4'h8, 32'hFFFF_FFFF, "R9 wr unused");
        apb_read(4'h8, rd); check("R9 unused", rd, 32'h0);
        apb_read(4'h0, rd); check("R9 ctrl kept", rd, 32'h002A_AAA8);

        // R6 soft reset from enabled state with other bits set
        wr_ok(4'h0, 32'h0055_5556, "R6 en");
        wait_flag(1'b1, n);
        wr_ok(4'h0, 32'h007F_FFFF, "R6 srst");
        check("R6 core_en drop", {31'b0, core_en}, 32'h0);
        wait_flag(1'b0, n); check("R6 rst length", n, SYNC);
        apb_read(4'h0, rd); check("R6 cleared", rd, 32'h0);
        apb_read(4'h4, rd); check("R6 busy clear", rd, 32'h0);

        // R8 read during reset
        wr_ok(4'h0, 32'h0000_0FF0, "R8 setup");
        wr_ok(4'h0, 32'h1, "R8 srst");
        apb_read(4'h0, rd); check("R8 read in rst", rd, 32'h1);
        wait_flag(1'b0, n);

        // R8 write during reset is rejected
        wr_ok(4'h0, 32'h1, "R8 srst2");
        apb_write(4'h0, 32'h007F_FFFE, e);
        check("R8 pslverr", {31'b0, e}, 32'h1);
        wait_flag(1'b0, n);
        repeat (2) @(negedge clk);
        apb_read(4'h0, rd); check("R8 ignored", rd, 32'h0);
        check("R8 no enable", {31'b0, core_en}, 32'h0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule